// File: doc/BRIEF.md
# Cross-Cluster Forward Request Arbiter

This block sits in the second select stage, between instruction selection and the compute clusters. Each cycle it looks at a small window of candidate instructions, one per slot. Each candidate has up to two source operands. A source whose register sits in a different cluster from the instruction's destination has to be forwarded from the cluster that owns it. The block decides which of those sources get a forward request in this cycle. A request is the source register address, driven on one of the owning cluster's forward-position outputs.

A register address is 10 bits wide. Its top three bits name the owning cluster: 0 is A, 1 is B, 2 is C, 3 is L and 4 is S. The lower seven bits select one of 128 registers in that cluster. Clusters B and S each have two forward positions and the others have one, which gives seven output ports.

A source may forward as soon as its READY bit is set. It does not wait for the scoreboard's PENDING bit, so issue and forward can happen in the same cycle. Each grant also drives a per-source pulse that the scoreboard uses to clear PENDING for that register. A candidate that loses arbitration gets no pulse. It competes again in the next cycle for as long as its instruction stays in the slot.

Top module: `xfwd_arbiter`

## Requirements
- R1: While rst_n is low, and on the first clock edge after it, every fwd_vld, fwd_addr and clr_pend bit is 0.
- R2: A source is requested only if its cluster (address bits [9:7]) differs from the cluster of its instruction's destination.
- R3: A source whose src_rdy bit is 0 is removed before arbitration, so it takes no port and does not count toward the per-cycle limit.
- R4: A ready, eligible source that is granted on clock edge N appears on the outputs right after edge N. This holds even in the first cycle its instruction is presented, with no earlier cycle needed.
- R5: The ports are numbered 0 to 6 as A, B first, B second, C, L, S first, S second. A granted source drives fwd_vld[p] = 1 and fwd_addr[10p+9:10p] = its address on a port p that belongs to its own cluster.
- R6: At most 4 sources are granted in one cycle, counted across all ports.
- R7: Candidates are served in fixed order: slot 0 first, and within a slot, source 0 (bit 2i of the source vectors) before source 1 (bit 2i+1). Inside a cluster, the earlier candidate takes the lower-numbered port.
- R8: A candidate that is refused for lack of a port, or because the cycle's limit is reached, gets no clr_pend pulse. It is served in a later cycle while its slot keeps the same instruction (cand_first = 0).
- R9: clr_pend[2i+s] pulses for exactly one cycle, aligned with the port outputs, for each source that was granted. The number of clr_pend bits set always equals the number of fwd_vld bits set.
- R10: Once a source has been granted, it is not requested again while its slot holds the same instruction. Setting cand_first for the slot, or clearing cand_vld, makes it eligible again.
- R11: No request is made for an invalid slot, for a source whose src_used bit is 0, or for a source whose cluster number is 5 or above (addresses 640 to 1023).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_vld | input | 4 | Slot holds an instruction |
| cand_first | input | 4 | First cycle of a new instruction in the slot |
| cand_dst | input | 40 | Destination register per slot, 10 bits each |
| cand_src | input | 80 | Source registers, 10 bits each, index 2*slot+source |
| src_rdy | input | 8 | READY bit of each source |
| src_used | input | 8 | Instruction actually reads this source |
| fwd_vld | output | 7 | Forward request valid per port |
| fwd_addr | output | 70 | Forwarded register address per port, 10 bits each |
| clr_pend | output | 8 | Clear PENDING for the granted source |

## Verification
The bench builds the block with its default parameters: four slots, a limit of four grants, five clusters, and two forward positions on B and S. With these values, eight candidate sources can compete for seven ports under a limit of four, so both the port limit and the per-cycle limit can actually bind. The 10-bit address also lets random stimulus place sources in cluster number 5. Because instructions are held across cycles, losers are retried and once-only serving is exercised.

// File: rtl/xfwd_pkg.sv
package xfwd_pkg;

   // number of forward positions owned by cluster c
   function automatic int ports_of(logic [31:0] dual_mask, int c);
      return dual_mask[c] ? 2 : 1;
   endfunction

   // first port index belonging to cluster c
   function automatic int base_of(logic [31:0] dual_mask, int c);
      int acc;
      acc = 0;
      for (int j = 0; j < 32; j++)
         if (j < c) acc += ports_of(dual_mask, j);
      return acc;
   endfunction

   // cluster that owns port p
   function automatic int clus_of_port(logic [31:0] dual_mask, int nclus, int p);
      int owner;
      owner = 0;
      for (int j = 0; j < 32; j++)
         if (j < nclus && p >= base_of(dual_mask, j)) owner = j;
      return owner;
   endfunction

endpackage

// File: rtl/xfwd_req_gen.sv
module xfwd_req_gen
   import xfwd_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int CLUS_W   = 3,
   parameter int NUM_CLUS = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vld,
   input  logic                first,
   input  logic [ADDR_W-1:0]   dst,
   input  logic [2*ADDR_W-1:0] src,
   input  logic [1:0]          rdy,
   input  logic [1:0]          used,
   input  logic [1:0]          gnt,
   output logic [1:0]          req,
   output logic [2*CLUS_W-1:0] req_clus
);

   localparam int CL_LSB = ADDR_W - CLUS_W;

   logic [1:0]        served_q;
   logic [1:0]        served_eff;
   logic [CLUS_W-1:0] dst_cl;
   logic              live_q;

   assign dst_cl     = dst[ADDR_W-1:CL_LSB];
   assign served_eff = first ? 2'b00 : served_q;

   for (genvar s = 0; s < 2; s++) begin : g_src
      logic [CLUS_W-1:0] src_cl;
      assign src_cl = src[s*ADDR_W+CL_LSB +: CLUS_W];
      assign req_clus[s*CLUS_W +: CLUS_W] = src_cl;
      assign req[s] = vld && used[s] && rdy[s] && !served_eff[s]
                      && (src_cl != dst_cl)
                      && (int'(src_cl) < NUM_CLUS);

      // R3: a granted source was ready
      a_r3_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
         gnt[s] |-> rdy[s]);
      // R2: a granted source is remote to its destination
      a_r2_grant_remote: assert property (@(posedge clk) disable iff (!rst_n)
         gnt[s] |-> (src_cl != dst_cl));
      // R10: the same instruction is not granted twice in a row
      a_r10_once: assert property (@(posedge clk) disable iff (!rst_n)
         (live_q && $past(gnt[s]) && $past(vld) && vld && !first) |-> !gnt[s]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         served_q <= '0;
         live_q   <= 1'b0;
      end else begin
         served_q <= vld ? (served_eff | gnt) : 2'b00;
         live_q   <= 1'b1;
      end
   end

endmodule

// File: rtl/xfwd_alloc.sv
module xfwd_alloc
   import xfwd_pkg::*;
#(
   parameter int          NREQ      = 8,
   parameter int          ADDR_W    = 10,
   parameter int          CLUS_W    = 3,
   parameter int          NUM_CLUS  = 5,
   parameter logic [31:0] DUAL_MASK = 32'h12,
   parameter int          MAX_FWD   = 4,
   parameter int          NPORTS    = 7
) (
   input  logic [NREQ-1:0]        req,
   input  logic [NREQ*CLUS_W-1:0] req_clus,
   input  logic [NREQ*ADDR_W-1:0] req_addr,
   output logic [NREQ-1:0]        gnt,
   output logic [NPORTS-1:0]      port_vld,
   output logic [NPORTS*ADDR_W-1:0] port_addr
);

   int used_c [NUM_CLUS];
   int total;
   int c;
   int p;

   // walk candidates in slot/source order, handing out ports
   always_comb begin
      gnt       = '0;
      port_vld  = '0;
      port_addr = '0;
      total     = 0;
      c         = 0;
      p         = 0;
      for (int j = 0; j < NUM_CLUS; j++) used_c[j] = 0;
      for (int k = 0; k < NREQ; k++) begin
         c = int'(req_clus[k*CLUS_W +: CLUS_W]);
         if (req[k] && total < MAX_FWD && c < NUM_CLUS) begin
            if (used_c[c] < ports_of(DUAL_MASK, c)) begin
               p = base_of(DUAL_MASK, c) + used_c[c];
               gnt[k]      = 1'b1;
               port_vld[p] = 1'b1;
               port_addr[p*ADDR_W +: ADDR_W] = req_addr[k*ADDR_W +: ADDR_W];
               used_c[c]   = used_c[c] + 1;
               total       = total + 1;
            end
         end
      end
   end

   // R6: combinational grant count respects the limit
   always_comb begin
      a_r6_alloc_cap: assert ($countones(gnt) <= MAX_FWD);
   end

endmodule

// File: rtl/xfwd_out_reg.sv
module xfwd_out_reg #(
   parameter int NREQ   = 8,
   parameter int NPORTS = 7,
   parameter int ADDR_W = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NREQ-1:0]          gnt_d,
   input  logic [NPORTS-1:0]        vld_d,
   input  logic [NPORTS*ADDR_W-1:0] addr_d,
   output logic [NREQ-1:0]          gnt_q,
   output logic [NPORTS-1:0]        vld_q,
   output logic [NPORTS*ADDR_W-1:0] addr_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_q  <= '0;
         vld_q  <= '0;
         addr_q <= '0;
      end else begin
         gnt_q  <= gnt_d;
         vld_q  <= vld_d;
         addr_q <= addr_d;
      end
   end

endmodule

// File: rtl/xfwd_arbiter.sv
module xfwd_arbiter
   import xfwd_pkg::*;
#(
   parameter int          NUM_SLOTS = 4,
   parameter int          ADDR_W    = 10,
   parameter int          CLUS_W    = 3,
   parameter int          NUM_CLUS  = 5,
   parameter logic [31:0] DUAL_MASK = 32'h12,
   parameter int          MAX_FWD   = 4,
   localparam int         NREQ      = 2 * NUM_SLOTS,
   localparam int         NPORTS    = base_of(DUAL_MASK, NUM_CLUS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SLOTS-1:0]        cand_vld,
   input  logic [NUM_SLOTS-1:0]        cand_first,
   input  logic [NUM_SLOTS*ADDR_W-1:0] cand_dst,
   input  logic [NREQ*ADDR_W-1:0]      cand_src,
   input  logic [NREQ-1:0]             src_rdy,
   input  logic [NREQ-1:0]             src_used,
   output logic [NPORTS-1:0]           fwd_vld,
   output logic [NPORTS*ADDR_W-1:0]    fwd_addr,
   output logic [NREQ-1:0]             clr_pend
);

   localparam int CL_LSB = ADDR_W - CLUS_W;

   // elaboration-time parameter checks
   if (NUM_CLUS > (1 << CLUS_W) || NUM_CLUS > 32) begin : g_bad_clus
      $error("xfwd_arbiter: NUM_CLUS does not fit the cluster field");
   end
   if (CLUS_W >= ADDR_W) begin : g_bad_width
      $error("xfwd_arbiter: cluster field wider than address");
   end
   if (MAX_FWD < 1 || NUM_SLOTS < 1) begin : g_bad_count
      $error("xfwd_arbiter: MAX_FWD and NUM_SLOTS must be positive");
   end

   logic [NREQ-1:0]          req;
   logic [NREQ*CLUS_W-1:0]   req_clus;
   logic [NREQ-1:0]          gnt;
   logic [NPORTS-1:0]        port_vld;
   logic [NPORTS*ADDR_W-1:0] port_addr;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      xfwd_req_gen #(
         .ADDR_W   (ADDR_W),
         .CLUS_W   (CLUS_W),
         .NUM_CLUS (NUM_CLUS)
      ) u_req (
         .clk      (clk),
         .rst_n    (rst_n),
         .vld      (cand_vld[i]),
         .first    (cand_first[i]),
         .dst      (cand_dst[i*ADDR_W +: ADDR_W]),
         .src      (cand_src[2*i*ADDR_W +: 2*ADDR_W]),
         .rdy      (src_rdy[2*i +: 2]),
         .used     (src_used[2*i +: 2]),
         .gnt      (gnt[2*i +: 2]),
         .req      (req[2*i +: 2]),
         .req_clus (req_clus[2*i*CLUS_W +: 2*CLUS_W])
      );
   end

   xfwd_alloc #(
      .NREQ      (NREQ),
      .ADDR_W    (ADDR_W),
      .CLUS_W    (CLUS_W),
      .NUM_CLUS  (NUM_CLUS),
      .DUAL_MASK (DUAL_MASK),
      .MAX_FWD   (MAX_FWD),
      .NPORTS    (NPORTS)
   ) u_alloc (
      .req       (req),
      .req_clus  (req_clus),
      .req_addr  (cand_src),
      .gnt       (gnt),
      .port_vld  (port_vld),
      .port_addr (port_addr)
   );

   xfwd_out_reg #(
      .NREQ   (NREQ),
      .NPORTS (NPORTS),
      .ADDR_W (ADDR_W)
   ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .gnt_d  (gnt),
      .vld_d  (port_vld),
      .addr_d (port_addr),
      .gnt_q  (clr_pend),
      .vld_q  (fwd_vld),
      .addr_q (fwd_addr)
   );

   // R6: registered grant count stays within the limit
   a_r6_out_cap: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(clr_pend) <= MAX_FWD);
   // R9: one pending clear per active forward port
   a_r9_clear_matches: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(clr_pend) == $countones(fwd_vld));

   // R5: each port only carries addresses of its own cluster
   for (genvar p = 0; p < NPORTS; p++) begin : g_port_chk
      localparam int OWNER = clus_of_port(DUAL_MASK, NUM_CLUS, p);
      a_r5_port_owner: assert property (@(posedge clk) disable iff (!rst_n)
         fwd_vld[p] |-> (int'(fwd_addr[p*ADDR_W+CL_LSB +: CLUS_W]) == OWNER));
   end

endmodule

// File: tb/tb_xfwd_arbiter.sv
module tb_xfwd_arbiter;

   localparam int CLK_PERIOD = 10;
   localparam int NS = 4;
   localparam int NR = 8;
   localparam int NP = 7;
   localparam int AW = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NS-1:0]     cand_vld;
   logic [NS-1:0]     cand_first;
   logic [NS*AW-1:0]  cand_dst;
   logic [NR*AW-1:0]  cand_src;
   logic [NR-1:0]     src_rdy;
   logic [NR-1:0]     src_used;
   logic [NP-1:0]     fwd_vld;
   logic [NP*AW-1:0]  fwd_addr;
   logic [NR-1:0]     clr_pend;

   logic [AW-1:0] b_dst [NS];
   logic [AW-1:0] b_src [NR];
   logic [NR-1:0] m_srv;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < NS; i++) cand_dst[i*AW +: AW] = b_dst[i];
      for (int k = 0; k < NR; k++) cand_src[k*AW +: AW] = b_src[k];
   end

   xfwd_arbiter dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cand_vld   (cand_vld),
      .cand_first (cand_first),
      .cand_dst   (cand_dst),
      .cand_src   (cand_src),
      .src_rdy    (src_rdy),
      .src_used   (src_used),
      .fwd_vld    (fwd_vld),
      .fwd_addr   (fwd_addr),
      .clr_pend   (clr_pend)
   );

   // port layout from R5
   function automatic int port_base(int c);
      case (c)
         0: return 0;
         1: return 1;
         2: return 3;
         3: return 4;
         default: return 5;
      endcase
   endfunction

   function automatic int port_cap(int c);
      return (c == 1 || c == 4) ? 2 : 1;
   endfunction

   task automatic set_slot(int i, logic v, logic f, logic [AW-1:0] d,
                           logic [AW-1:0] s0, logic [AW-1:0] s1,
                           logic r0, logic r1, logic u0, logic u1);
      cand_vld[i]   = v;
      cand_first[i] = f;
      b_dst[i]      = d;
      b_src[2*i]    = s0;
      b_src[2*i+1]  = s1;
      src_rdy[2*i]  = r0;  src_rdy[2*i+1]  = r1;
      src_used[2*i] = u0;  src_used[2*i+1] = u1;
   endtask

   task automatic clear_all();
      for (int i = 0; i < NS; i++) set_slot(i, 0, 0, '0, '0, '0, 0, 0, 0, 0);
   endtask

   function automatic logic [AW-1:0] ra(int c, int r);
      return AW'(c * 128 + r);
   endfunction

   // compute expected outputs for the present inputs, clock, compare
   task automatic step(string tag);
      logic [NP-1:0]    e_vld;
      logic [NP*AW-1:0] e_addr;
      logic [NR-1:0]    e_gnt;
      logic [NR-1:0]    n_srv;
      int pc [5];
      int tot;
      e_vld = '0; e_addr = '0; e_gnt = '0; n_srv = '0; tot = 0;
      for (int c = 0; c < 5; c++) pc[c] = 0;
      for (int i = 0; i < NS; i++) begin
         for (int s = 0; s < 2; s++) begin
            int k;
            int cs;
            int cd;
            logic eff;
            logic ok;
            k   = 2*i + s;
            eff = cand_first[i] ? 1'b0 : m_srv[k];
            cs  = int'(b_src[k][9:7]);
            cd  = int'(b_dst[i][9:7]);
            ok  = cand_vld[i] && src_used[k] && src_rdy[k] && !eff && cs != cd && cs < 5;
            if (ok && tot < 4 && pc[cs] < port_cap(cs)) begin
               int p;
               p = port_base(cs) + pc[cs];
               e_vld[p] = 1'b1;
               e_addr[p*AW +: AW] = b_src[k];
               e_gnt[k] = 1'b1;
               pc[cs]++;
               tot++;
            end
            n_srv[k] = cand_vld[i] ? (eff | e_gnt[k]) : 1'b0;
         end
      end
      @(posedge clk);
      @(negedge clk);
      n_chk++;
      if (fwd_vld !== e_vld || fwd_addr !== e_addr || clr_pend !== e_gnt) begin
         n_fail++;
         $display("FAIL %s: vld=%b addr=%h clr=%b expected vld=%b addr=%h clr=%b",
                  tag, fwd_vld, fwd_addr, clr_pend, e_vld, e_addr, e_gnt);
      end
      m_srv = n_srv;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int k = 0; k < NR; k++) b_src[k] = '0;
      for (int i = 0; i < NS; i++) b_dst[i] = '0;
      cand_vld = '0; cand_first = '0; src_rdy = '0; src_used = '0;
      m_srv = '0;
      // R1: outputs idle during reset, even with requests present
      set_slot(0, 1, 1, ra(0,1), ra(1,2), ra(2,3), 1, 1, 1, 1);
      repeat (3) @(negedge clk);
      n_chk++;
      if (fwd_vld !== '0 || fwd_addr !== '0 || clr_pend !== '0) begin
         n_fail++;
         $display("FAIL R1: vld=%b clr=%b expected 0", fwd_vld, clr_pend);
      end
      clear_all();
      rst_n = 1'b1;
      step("R1");

      // R2: same-cluster source gets nothing, remote one goes to port 1 (B)
      set_slot(0, 1, 1, ra(0,5), ra(0,9), ra(1,7), 1, 1, 1, 1);
      step("R2");
      clear_all(); step("R2");

      // R3: unready B source does not take a B port
      set_slot(0, 1, 1, ra(0,1), ra(1,10), ra(0,0), 0, 0, 1, 0);
      set_slot(1, 1, 1, ra(0,2), ra(1,11), ra(0,0), 1, 0, 1, 0);
      set_slot(2, 1, 1, ra(2,3), ra(1,12), ra(0,0), 1, 0, 1, 0);
      step("R3");
      clear_all(); step("R3");

      // R4/R9: first-cycle ready source granted at the next edge, pulse once
      set_slot(3, 1, 1, ra(4,1), ra(3,44), ra(2,17), 1, 1, 1, 1);
      step("R4");
      cand_first[3] = 1'b0;
      step("R9");
      clear_all(); step("R9");

      // R6: eight eligible sources, only four granted
      set_slot(0, 1, 1, ra(0,0), ra(1,1), ra(2,2), 1, 1, 1, 1);
      set_slot(1, 1, 1, ra(0,0), ra(3,3), ra(4,4), 1, 1, 1, 1);
      set_slot(2, 1, 1, ra(0,0), ra(1,5), ra(4,6), 1, 1, 1, 1);
      set_slot(3, 1, 1, ra(1,0), ra(0,7), ra(2,8), 1, 1, 1, 1);
      step("R6");
      cand_first = '0;
      step("R8");
      step("R8");
      clear_all(); step("R6");

      // R7/R8/R10: three slots want the single A port, one per cycle
      set_slot(0, 1, 1, ra(2,0), ra(0,20), ra(0,0), 1, 0, 1, 0);
      set_slot(1, 1, 1, ra(2,0), ra(0,21), ra(0,0), 1, 0, 1, 0);
      set_slot(2, 1, 1, ra(2,0), ra(0,22), ra(0,0), 1, 0, 1, 0);
      step("R7");
      cand_first = '0;
      step("R8");
      step("R8");
      step("R10");
      cand_first[0] = 1'b1;
      step("R10");
      clear_all(); step("R10");

      // R11: invalid slot, unused source, cluster 5
      set_slot(0, 0, 1, ra(0,0), ra(1,1), ra(2,2), 1, 1, 1, 1);
      set_slot(1, 1, 1, ra(0,0), ra(1,1), ra(2,2), 1, 1, 0, 0);
      set_slot(2, 1, 1, ra(0,0), ra(5,3), ra(7,4), 1, 1, 1, 1);
      step("R11");
      clear_all(); step("R11");

      // R5/R7: random traffic with held instructions
      for (int n = 0; n < 3000; n++) begin
         for (int i = 0; i < NS; i++) begin
            if (!cand_vld[i] || ($urandom % 4) == 0) begin
               set_slot(i, ($urandom % 5) != 0, 1'b1,
                        ra($urandom % 5, $urandom % 128),
                        ra($urandom % 6, $urandom % 128),
                        ra($urandom % 6, $urandom % 128),
                        $urandom % 2, $urandom % 2,
                        ($urandom % 4) != 0, ($urandom % 4) != 0);
            end else begin
               cand_first[i] = 1'b0;
               if (($urandom % 3) == 0) src_rdy[2*i]   = 1'b1;
               if (($urandom % 3) == 0) src_rdy[2*i+1] = 1'b1;
            end
         end
         step("R5");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule